// File: doc/BRIEF.md
# Ternary Set-Valued Gate Evaluator

This block evaluates one ternary logic primitive, or one parallel stage of two lines, per clock cycle. Every line is a three-bit presence mask. Each bit stands for one of the logic values 0, 1 and 2, so a single line can carry one value, several values at once, or no value at all. The empty mask is distinct from logic 0. An analysis flow that wants the outputs for a whole family of stimuli can give sets of values on the inputs. One evaluation then returns the union of every reachable result.

A three-bit opcode selects the primitive. The choices are two-input minimum, two-input maximum, the three literal selectors, a pass-through of both lines, a fanout of one line onto two, and a wired fanin of two lines. The result and the opcode are registered together. A valid flag follows the input flag by one cycle. Logic values may collide on a fanin. A collision gives no error: that combination adds no value to the output mask.

Top module: `tset_gate_eval`

## Requirements
- R1: Mask bit k (k = 0, 1, 2) is set when logic value k is present. A single value k is the mask with only bit k set, and 3'b000 is the empty set. Outputs `res_a`, `res_b`, `op_q` and `out_vld` are registered. `out_vld` equals the `in_vld` of the previous cycle, and every output is zero while `rst_n` is low.
- R2: Opcode 3'd0 (minimum) sets bit k of `res_a` exactly when some value x present in `ln_a` and some value y present in `ln_b` satisfy min(x,y) = k.
- R3: Opcode 3'd1 (maximum) sets bit k of `res_a` exactly when some present pair (x,y) satisfies max(x,y) = k.
- R4: Opcodes 3'd2, 3'd3 and 3'd4 are literal selectors for i = 0, 1, 2. Each maps a present input value equal to i to output value 2 and any other present value to output value 0. They act on `ln_a`.
- R5: Opcode 3'd5 (pass-through) copies `ln_a` to `res_a` and `ln_b` to `res_b`.
- R6: Opcode 3'd6 (fanout) copies `ln_a` onto both `res_a` and `res_b`.
- R7: Opcode 3'd7 (fanin) yields only the values present on both lines. Two different single values give 3'b000.
- R8: For opcodes 3'd0, 3'd1 and 3'd7, an empty mask on either input gives an empty `res_a`. For opcodes 3'd2 to 3'd4, an empty `ln_a` gives an empty `res_a`.
- R9: For every opcode other than 3'd5 and 3'd6, `res_b` is 3'b000.
- R10: `op_q` carries the opcode that was applied one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input operands are meaningful |
| op | input | 3 | Primitive select |
| ln_a | input | 3 | First input line, presence mask |
| ln_b | input | 3 | Second input line, presence mask |
| out_vld | output | 1 | Registered copy of in_vld |
| op_q | output | 3 | Registered opcode |
| res_a | output | 3 | First output line, presence mask |
| res_b | output | 3 | Second output line, presence mask |

## Verification
The block has no parameters, so the bench runs it in its only form. There are just eight opcodes and eight mask values per line, which gives 512 evaluations. The bench applies every one of them, so every set-valued combination is covered, including the empty and full masks. The expected masks come from enumerating value pairs with integer minimum, maximum and equality. A gap with the input flag low confirms that the valid flag follows the input flag.

// File: rtl/tset_gate_eval.sv
module tset_gate_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [2:0] op,
  input  logic [2:0] ln_a,
  input  logic [2:0] ln_b,
  output logic       out_vld,
  output logic [2:0] op_q,
  output logic [2:0] res_a,
  output logic [2:0] res_b
);

  localparam logic [2:0] OP_MIN  = 3'd0;
  localparam logic [2:0] OP_MAX  = 3'd1;
  localparam logic [2:0] OP_J0   = 3'd2;
  localparam logic [2:0] OP_J2   = 3'd4;
  localparam logic [2:0] OP_PASS = 3'd5;
  localparam logic [2:0] OP_FO   = 3'd6;
  localparam logic [2:0] OP_FI   = 3'd7;

  logic       any_a, any_b;
  logic [2:0] mn, mx, fi;
  logic [2:0] lit [3];
  logic [2:0] nxt_a, nxt_b;

  assign any_a = |ln_a;
  assign any_b = |ln_b;

  assign mn[0] = (ln_a[0] & any_b) | (ln_b[0] & any_a);
  assign mn[1] = (ln_a[1] & (ln_b[1] | ln_b[2])) | (ln_b[1] & (ln_a[1] | ln_a[2]));
  assign mn[2] = ln_a[2] & ln_b[2];

  assign mx[2] = (ln_a[2] & any_b) | (ln_b[2] & any_a);
  assign mx[1] = (ln_a[1] & (ln_b[1] | ln_b[0])) | (ln_b[1] & (ln_a[1] | ln_a[0]));
  assign mx[0] = ln_a[0] & ln_b[0];

  assign fi = ln_a & ln_b;

  for (genvar i = 0; i < 3; i++) begin : g_lit
    logic [2:0] sel;
    assign sel    = 3'b001 << i;
    assign lit[i] = {|(ln_a & sel), 1'b0, |(ln_a & ~sel)};
  end

  always_comb begin
    nxt_a = 3'b000;
    nxt_b = 3'b000;
    case (op)
      OP_MIN:  nxt_a = mn;
      OP_MAX:  nxt_a = mx;
      OP_PASS: begin nxt_a = ln_a; nxt_b = ln_b; end
      OP_FO:   begin nxt_a = ln_a; nxt_b = ln_a; end
      OP_FI:   nxt_a = fi;
      default: nxt_a = lit[op - OP_J0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      op_q    <= 3'b000;
      res_a   <= 3'b000;
      res_b   <= 3'b000;
    end else begin
      out_vld <= in_vld;
      op_q    <= op;
      res_a   <= nxt_a;
      res_b   <= nxt_b;
    end
  end

  a_r8_empty_gives_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (op_q == OP_MIN || op_q == OP_MAX || op_q == OP_FI) &&
     ($past(ln_a) == 3'b000 || $past(ln_b) == 3'b000)) |-> (res_a == 3'b000));

  a_r9_second_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && op_q != OP_PASS && op_q != OP_FO) |-> (res_b == 3'b000));

  a_r6_fanout_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && op_q == OP_FO) |-> (res_a == res_b && res_a == $past(ln_a)));

  a_r7_fanin_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && op_q == OP_FI) |-> ((res_a & ~$past(ln_a)) == 3'b000 && (res_a & ~$past(ln_b)) == 3'b000));

  a_r2_single_min_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && op_q == OP_MIN && $countones($past(ln_a)) == 1 && $countones($past(ln_b)) == 1)
      |-> ($countones(res_a) == 1));

  a_r4_literal_no_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && op_q >= OP_J0 && op_q <= OP_J2) |-> (res_a[1] == 1'b0));

  a_r10_opcode_tag: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (op_q == $past(op)));

endmodule

// File: tb/tset_gate_eval_test.sv
module tset_gate_eval_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [2:0] op = '0, ln_a = '0, ln_b = '0;
  logic       out_vld;
  logic [2:0] op_q, res_a, res_b;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  tset_gate_eval uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .ln_a(ln_a),
                      .ln_b(ln_b), .out_vld(out_vld), .op_q(op_q), .res_a(res_a), .res_b(res_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_a(input logic [2:0] o, input logic [2:0] a, input logic [2:0] b);
    logic [2:0] r = '0;
    for (int x = 0; x < 3; x++) begin
      if (o >= 3'd2 && o <= 3'd4 && a[x]) r[(x == int'(o) - 2) ? 2 : 0] = 1'b1;
      for (int y = 0; y < 3; y++) if (a[x] && b[y]) begin
        if (o == 3'd0) r[(x < y) ? x : y] = 1'b1;
        if (o == 3'd1) r[(x > y) ? x : y] = 1'b1;
        if (o == 3'd7 && x == y) r[x] = 1'b1;
      end
    end
    if (o == 3'd5 || o == 3'd6) r = a;
    return r;
  endfunction

  function automatic logic [2:0] exp_b(input logic [2:0] o, input logic [2:0] a, input logic [2:0] b);
    return (o == 3'd5) ? b : (o == 3'd6) ? a : 3'b000;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd5: return "R5";
      3'd6: return "R6";
      3'd7: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, want);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset res_a", {1'b0, res_a}, 4'd0);
    check("R1 reset res_b", {1'b0, res_b}, 4'd0);
    check("R1 reset vld", {3'b0, out_vld}, 4'd0);
    check("R10 reset op_q", {1'b0, op_q}, 4'd0);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          op = 3'(o); ln_a = 3'(a); ln_b = 3'(b); in_vld = 1'b1;
          @(negedge clk);
          check({req_of(op), " res_a"}, {1'b0, res_a}, {1'b0, exp_a(op, ln_a, ln_b)});
          check((op == 3'd5 || op == 3'd6) ? {req_of(op), " res_b"} : "R9 res_b",
                {1'b0, res_b}, {1'b0, exp_b(op, ln_a, ln_b)});
          check("R10 op_q", {1'b0, op_q}, {1'b0, op});
          check("R1 out_vld", {3'b0, out_vld}, 4'd1);
          if ((a == 0 || b == 0) && (o <= 1 || o == 7)) check("R8 empty", {1'b0, res_a}, 4'd0);
          if (o == 7 && a != b && $countones(3'(a)) == 1 && $countones(3'(b)) == 1)
            check("R7 conflict", {1'b0, res_a}, 4'd0);
        end
    in_vld = 1'b0;
    @(negedge clk);
    check("R1 vld drop", {3'b0, out_vld}, 4'd0);
    in_vld = 1'b1;
    @(negedge clk);
    check("R1 vld rise", {3'b0, out_vld}, 4'd1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule